// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a free-running watchdog for a small microcontroller bus. The bus clock feeds a fixed power-of-two prescaler of 2^PRE_W cycles, with PRE_W set to 15 in silicon. A second stage then divides by 1, 4, 16 or 64, picked by a two-bit rate code. If software lets the second stage run out, the block pulses a system reset request for one bus cycle and starts counting again. A reset sequencer outside the block acts on that pulse.

Software keeps the timer alive with a two-step key on the service register. A write of 0x55 arms the clear, and a later write of 0xAA clears the time-out count. Any other bus traffic may come between the two writes. The prescaler is not restarted by a clear, so the time left after a service can exceed the nominal figure by up to one prescaler period but never falls short of it. In normal mode the rate code can be written once, and only in a short window after reset. A configuration input switches the whole watchdog off. In test mode, a suppress bit is set out of reset and blocks the reset request until software writes it to zero.

Top module: `wdk_watchdog`

## Requirements
- R1: Out of reset, rst_req is low and rate_sel reads 00.
- R2: With no service, rst_req pulses at every bus cycle that is a multiple of N·2^PRE_W counted from reset release. N is 1, 4, 16 or 64 for rate codes 00, 01, 10 and 11.
- R3: Each reset request lasts exactly one cycle, and the time-out count then restarts from zero.
- R4: A clear write (0xAA) taken at cycle s, while the sequence is armed, moves the next request to cycle (floor(s/2^PRE_W)+1+N)·2^PRE_W. That is at least N·2^PRE_W+1 and at most (N+1)·2^PRE_W cycles later. Writes may sit between the arm and the clear.
- R5: A write of 0xAA while the sequence is not armed does not change the time-out.
- R6: A write of 0x55 arms the sequence. Writes of any other value leave the armed state unchanged. A completed clear disarms, so a second lone 0xAA has no effect.
- R7: In normal mode (test_mode=0), a rate write (code in wr_data[1:0]) is accepted if it is the first rate write and falls within bus cycles 1 to WIN after reset release (WIN=64).
- R8: In normal mode, rate writes after the first accepted one, or after cycle WIN, leave rate_sel unchanged.
- R9: While cfg_disable is 1, both counters are held at zero and rst_req stays low.
- R10: In test mode, the suppress bit is 1 out of reset and rst_req stays low. The counters still run and restart silently. Writing wr_data[0]=0 through wr_inhib lets the next time-out raise rst_req.
- R11: In test mode, rate writes are accepted at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_disable | input | 1 | Configuration bit; 1 turns the watchdog off |
| test_mode | input | 1 | 1 selects test/bootstrap behaviour |
| wr_svc | input | 1 | Write strobe for the service register |
| wr_rate | input | 1 | Write strobe for the rate register |
| wr_inhib | input | 1 | Write strobe for the reset-suppress bit |
| wr_data | input | 8 | Write data shared by the three registers |
| rate_sel | output | 2 | Current rate code |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The assertions cover the properties that hold on every cycle. A request never lasts two cycles and always lines up with a prescaler tick. It stays low while the block is disabled or suppressed. The rate code never changes without a write, and never changes once the window has closed in normal mode. The arm flag sets and clears only on the proper key values. The exact cycle of each request depends on history: the prescaler phase at the moment of the clear, stray unarmed clears, junk values between arm and clear, and when suppression is lifted. Only the bench's cycle-accurate scenarios can show these, including a clear that lands on the same cycle as a time-out.

// File: rtl/wdk_pkg.sv
package wdk_pkg;

    localparam int RATE_W   = 2;
    localparam int MAX_CODE = (1 << RATE_W) - 1;
    localparam int DIV_W    = 2 * MAX_CODE;

    localparam logic [7:0] KEY_ARM = 8'h55;
    localparam logic [7:0] KEY_CLR = 8'hAA;

    typedef logic [RATE_W-1:0] rate_t;

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             hold;
        logic             req;
    } tmo_t;

    typedef struct packed {
        logic armed;
    } key_t;

    function automatic logic [DIV_W-1:0] last_step(rate_t code);
        logic [DIV_W:0] n;
        n = (DIV_W+1)'(1) << (2 * code);
        return DIV_W'(n - (DIV_W+1)'(1));
    endfunction

endpackage

// File: rtl/wdk_prescaler.sv
module wdk_prescaler #(
    parameter int PRE_W = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_t;

    pre_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (run) begin
            st_d.cnt = st_q.cnt + PRE_W'(1);
        end else begin
            st_d.cnt = '0;
        end
    end

    assign tick = run && (&st_q.cnt);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/wdk_key.sv
module wdk_key
    import wdk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_svc,
    input  logic [7:0] wr_data,
    output logic       armed,
    output logic       clr
);

    key_t st_d, st_q;

    assign clr   = wr_svc && (wr_data == KEY_CLR) && st_q.armed;
    assign armed = st_q.armed;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.armed = 1'b0;
        end else if (wr_svc && (wr_data == KEY_ARM)) begin
            st_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/wdk_ratecfg.sv
module wdk_ratecfg
    import wdk_pkg::*;
#(
    parameter int WIN = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       test_mode,
    input  logic       wr_rate,
    input  logic       wr_inhib,
    input  logic [7:0] wr_data,
    output rate_t      rate,
    output logic       inhibit,
    output logic       win_open
);

    localparam int WIN_W = $clog2(WIN + 1);

    typedef struct packed {
        logic [WIN_W-1:0] win;
        logic             locked;
        rate_t            rate;
        logic             inhib;
    } cfg_t;

    cfg_t st_d, st_q;
    logic accept;

    assign win_open = st_q.win < WIN_W'(WIN);
    assign accept   = wr_rate && (test_mode || (!st_q.locked && win_open));

    always_comb begin
        st_d = st_q;
        if (win_open) begin
            st_d.win = st_q.win + WIN_W'(1);
        end
        if (accept) begin
            st_d.rate = wr_data[RATE_W-1:0];
            if (!test_mode) begin
                st_d.locked = 1'b1;
            end
        end
        if (wr_inhib) begin
            st_d.inhib = wr_data[0];
        end
    end

    assign rate    = st_q.rate;
    assign inhibit = st_q.inhib;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.inhib <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/wdk_watchdog.sv
module wdk_watchdog
    import wdk_pkg::*;
#(
    parameter int PRE_W = 15,
    parameter int WIN   = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_disable,
    input  logic       test_mode,
    input  logic       wr_svc,
    input  logic       wr_rate,
    input  logic       wr_inhib,
    input  logic [7:0] wr_data,
    output logic [1:0] rate_sel,
    output logic       rst_req
);

    logic  run;
    logic  tick;
    logic  armed;
    logic  clr;
    logic  inhibit;
    logic  win_open;
    rate_t rate;
    logic  term;
    tmo_t  tm_d, tm_q;

    assign run = !cfg_disable;

    wdk_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .tick (tick)
    );

    wdk_key u_key (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_svc (wr_svc),
        .wr_data(wr_data),
        .armed  (armed),
        .clr    (clr)
    );

    wdk_ratecfg #(.WIN(WIN)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .test_mode(test_mode),
        .wr_rate  (wr_rate),
        .wr_inhib (wr_inhib),
        .wr_data  (wr_data),
        .rate     (rate),
        .inhibit  (inhibit),
        .win_open (win_open)
    );

    assign term = tm_q.cnt >= last_step(rate);

    always_comb begin
        tm_d     = tm_q;
        tm_d.req = 1'b0;
        if (!run) begin
            tm_d.cnt  = '0;
            tm_d.hold = 1'b0;
        end else begin
            if (tick) begin
                if (tm_q.hold) begin
                    tm_d.hold = 1'b0;
                end else if (term) begin
                    tm_d.cnt = '0;
                    tm_d.req = !(test_mode && inhibit);
                end else begin
                    tm_d.cnt = tm_q.cnt + DIV_W'(1);
                end
            end
            if (clr) begin
                tm_d.cnt  = '0;
                tm_d.hold = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tm_q <= '0;
        end else begin
            tm_q <= tm_d;
        end
    end

    assign rate_sel = rate;
    assign rst_req  = tm_q.req;

endmodule

// File: rtl/wdk_chk.sv
module wdk_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_disable,
    input logic       test_mode,
    input logic       wr_svc,
    input logic       wr_rate,
    input logic [7:0] wr_data,
    input logic [1:0] rate_sel,
    input logic       rst_req,
    input logic       tick,
    input logic       armed,
    input logic       clr,
    input logic       inhibit,
    input logic       win_open
);

    // R3
    pulse_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R2
    req_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> $past(tick));

    // R9
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_disable |=> !rst_req);

    // R10
    suppress_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode && inhibit) |=> !rst_req);

    // R8
    window_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_mode && !win_open) |=> $stable(rate_sel));

    // R7
    rate_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel != $past(rate_sel)) |-> $past(wr_rate));

    // R6
    arm_on_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_svc && wr_data == 8'h55) |=> armed);

    // R6
    arm_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(wr_svc && wr_data == 8'h55));

    // R4
    clear_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !armed);

endmodule

bind wdk_watchdog wdk_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_disable(cfg_disable),
    .test_mode  (test_mode),
    .wr_svc     (wr_svc),
    .wr_rate    (wr_rate),
    .wr_data    (wr_data),
    .rate_sel   (rate_sel),
    .rst_req    (rst_req),
    .tick       (tick),
    .armed      (armed),
    .clr        (clr),
    .inhibit    (inhibit),
    .win_open   (win_open)
);

// File: tb/tb_wdk_watchdog.sv
module tb_wdk_watchdog;

    localparam int PRE_W = 7;
    localparam int PER   = 1 << PRE_W;
    localparam int WIN   = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_disable = 1'b0;
    logic       test_mode = 1'b0;
    logic       wr_svc = 1'b0;
    logic       wr_rate = 1'b0;
    logic       wr_inhib = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] rate_sel;
    logic       rst_req;

    wdk_watchdog #(.PRE_W(PRE_W), .WIN(WIN)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_disable(cfg_disable),
        .test_mode  (test_mode),
        .wr_svc     (wr_svc),
        .wr_rate    (wr_rate),
        .wr_inhib   (wr_inhib),
        .wr_data    (wr_data),
        .rate_sel   (rate_sel),
        .rst_req    (rst_req)
    );

    always #5 clk = ~clk;

    int cyc;
    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    int         n_checks = 0;
    int         n_fail   = 0;
    int         exp_edge;
    int         last_restart;
    int         clr_edge;
    bit         model_off;
    bit         model_inhib;
    bit         armed_m;
    bit         locked_m;
    logic [1:0] rate_m;

    function automatic int div_of(logic [1:0] c);
        return 1 << (2 * int'(c));
    endfunction

    function automatic int after_clear(int s, int n);
        return (s / PER + 1 + n) * PER;
    endfunction

    function automatic logic [7:0] junk();
        logic [7:0] v;
        do v = 8'($urandom_range(0, 255)); while (v == 8'h55 || v == 8'hAA);
        return v;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic step(string req);
        bit hit;
        @(negedge clk);
        hit = !model_off && (cyc == exp_edge);
        chk(req, int'(rst_req), int'(hit && !model_inhib));
        if (hit) begin
            last_restart = cyc;
            exp_edge     = cyc + div_of(rate_m) * PER;
        end
        if (!model_off && cyc == clr_edge) begin
            exp_edge = after_clear(cyc, div_of(rate_m));
        end
        wr_svc   = 1'b0;
        wr_rate  = 1'b0;
        wr_inhib = 1'b0;
    endtask

    task automatic idle(string req, int n);
        repeat (n) step(req);
    endtask

    task automatic idle_to(string req, int target);
        while (cyc < target) step(req);
    endtask

    task automatic do_reset(bit tm, bit dis);
        rst_n       = 1'b0;
        wr_svc      = 1'b0;
        wr_rate     = 1'b0;
        wr_inhib    = 1'b0;
        test_mode   = tm;
        cfg_disable = dis;
        repeat (3) @(negedge clk);
        rst_n        = 1'b1;
        rate_m       = 2'b00;
        exp_edge     = PER;
        last_restart = 0;
        clr_edge     = -1;
        armed_m      = 1'b0;
        locked_m     = 1'b0;
        model_off    = dis;
        model_inhib  = tm;
        chk("R1 rst_req", int'(rst_req), 0);
        chk("R1 rate_sel", int'(rate_sel), 0);
    endtask

    task automatic svc(string req, logic [7:0] v);
        int s;
        s = cyc + 1;
        wr_svc  = 1'b1;
        wr_data = v;
        if (v == 8'h55) armed_m = 1'b1;
        else if (v == 8'hAA && armed_m) begin
            armed_m  = 1'b0;
            clr_edge = s;
        end
        step(req);
    endtask

    task automatic rate_wr(string req, logic [1:0] v);
        int  s;
        bit  acc;
        s   = cyc + 1;
        acc = test_mode || (!locked_m && s <= WIN);
        wr_rate = 1'b1;
        wr_data = {6'b0, v};
        step(req);
        if (acc) begin
            rate_m = v;
            if (!test_mode) locked_m = 1'b1;
            exp_edge = last_restart + div_of(v) * PER;
        end
        chk(req, int'(rate_sel), int'(rate_m));
    endtask

    task automatic inhib_wr(logic v);
        wr_inhib = 1'b1;
        wr_data  = {7'b0, v};
        step("R10");
        model_inhib = test_mode && v;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));

        // R1 R2 R3: unserviced pulses at rate 00
        do_reset(1'b0, 1'b0);
        idle("R2", 3 * PER + 5);

        // R7: last cycle of window accepted; R8: second write ignored; R2 at /16
        do_reset(1'b0, 1'b0);
        idle_to("R7", WIN - 1);
        rate_wr("R7 last window cycle", 2'b10);
        rate_wr("R8 second write", 2'b01);
        idle("R2", 16 * PER + 10);

        // R8: write one cycle past the window
        do_reset(1'b0, 1'b0);
        idle_to("R8", WIN);
        rate_wr("R8 past window", 2'b11);
        idle("R8", 2 * PER);

        // R5: lone clears do nothing
        do_reset(1'b0, 1'b0);
        rate_wr("R7", 2'b01);
        idle_to("R5", 300);
        svc("R5", 8'hAA);
        svc("R5", 8'h12);
        svc("R5", 8'hAA);
        idle_to("R5", 4 * PER + 20);

        // R6: junk keeps armed, repeated arm, second lone clear ignored
        do_reset(1'b0, 1'b0);
        rate_wr("R7", 2'b01);
        idle_to("R6", 200);
        svc("R6", 8'h55);
        svc("R6", 8'h00);
        svc("R6", 8'hFF);
        svc("R6", 8'h54);
        svc("R6", 8'h55);
        idle("R6", 40);
        svc("R6", 8'hAB);
        svc("R4", 8'hAA);
        idle("R6", 100);
        svc("R6", 8'hAA);
        idle("R6", 6 * PER);

        // R4: clear on the same cycle as a time-out, and just after a boundary
        do_reset(1'b0, 1'b0);
        idle_to("R4", 99);
        svc("R4", 8'h55);
        idle_to("R4", PER - 1);
        svc("R4 clear on boundary", 8'hAA);
        idle_to("R4", 2 * PER + 70);
        svc("R4", 8'h55);
        idle_to("R4", 4 * PER);
        svc("R4 clear after boundary", 8'hAA);
        idle("R4", 3 * PER);

        // R2: slowest rate
        do_reset(1'b0, 1'b0);
        idle_to("R2", 9);
        rate_wr("R7", 2'b11);
        idle("R2", 64 * PER + 10);

        // R9: disabled
        do_reset(1'b0, 1'b1);
        idle("R9", 3 * PER);
        svc("R9", 8'h55);
        svc("R9", 8'hAA);
        idle("R9", 2 * PER);

        // R10 R11: test mode suppression, release, late rate write
        do_reset(1'b1, 1'b0);
        idle_to("R10", 300);
        inhib_wr(1'b0);
        idle_to("R10", 3 * PER + 10);
        rate_wr("R11 late rate write", 2'b01);
        idle("R10", 5 * PER);
        rate_wr("R11 second late write", 2'b00);

        // random mix
        for (int it = 0; it < 10; it++) begin
            logic [1:0] r;
            do_reset(1'b0, 1'b0);
            r = 2'($urandom_range(0, 2));
            idle_to("R7", $urandom_range(0, 39));
            rate_wr("R7 random", r);
            for (int k = 0; k < 3; k++) begin
                idle("R2", $urandom_range(0, div_of(r) * PER / 2));
                repeat ($urandom_range(0, 3)) svc("R6", junk());
                if ($urandom_range(0, 1) == 1) svc("R5", 8'hAA);
                svc("R4", 8'h55);
                repeat ($urandom_range(0, 2)) begin
                    idle("R4", $urandom_range(0, 20));
                    svc("R6", junk());
                end
                svc("R4", 8'hAA);
            end
            idle("R4", (div_of(r) + 1) * PER + 4);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule